// File: doc/BRIEF.md
# Multi-Set Coefficient Bank

This block stores the tap coefficients for a pair of symmetric FIR filter engines and presents one coefficient set per filter to the pre-add multipliers on every clock. Each filter owns four banks of 32 ten-bit words. A set is the group of words that share one index across the four banks, so a set delivers the four multiplier coefficients of one filter at once.

Software or a loader writes coefficients with a strobe that has no fixed phase relation to the filter clock. On the rising edge of the strobe a 9-bit structured address and a 10-bit data word are captured. The address carries a mandatory tag bit, a set number, a filter bit and a bank number. The captured write is carried into the filter clock domain with a toggle synchronizer, and only then does it update storage. A 5-bit set select is registered on each clock, so the filter may switch coefficient sets from one sample to the next.

Top module: `coef_set_store`

## Requirements
- R1: Storage holds 2 filters x 4 banks x 32 words of 10 bits, and every word reads as zero after reset.
- R2: The write address decodes as bank = addr[1:0], filter = addr[2] (0 selects the A filter, 1 the B filter), set = addr[7:3].
- R3: A write takes effect only when addr[8] is 1. A write with addr[8] at 0 leaves every stored word unchanged.
- R4: Address and data are captured on the rising edge of wr_strb, which may fall anywhere within the clock period. Changes to wr_addr or wr_data after that edge do not alter the write.
- R5: A write is visible at the outputs no later than the fifth rising clock edge after the strobe edge, and it changes only the addressed word.
- R6: coef_a and coef_b carry bank k of the selected set in bits [10k+9:10k]. The set that set_sel holds at a clock edge appears after that edge, and the selection may change on every clock.
- R7: The outputs hold their value while set_sel is unchanged and no write commits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_strb | input | 1 | Write strobe, rising edge captures, asynchronous to clk |
| wr_addr | input | 9 | Structured write address: tag, set, filter, bank |
| wr_data | input | 10 | Coefficient word to write |
| set_sel | input | 5 | Coefficient set to drive to the multipliers |
| coef_a | output | 40 | Four coefficients of the A filter, bank 0 in the low bits |
| coef_b | output | 40 | Four coefficients of the B filter, bank 0 in the low bits |

## Verification
The assertions take for granted that strobe rising edges are at least six clock periods apart and that address and data are steady at each strobe edge. Under those conditions the synchronized commit pulse is never high on two clocks in a row, and the held address stays fixed until the commit. The stimulus writes through a task that spaces every strobe by six or more clocks and places its edge at a random offset within the clock period. After the edge it may scramble the address and data to show that only the captured values count. Random addresses include tag-clear writes, and a directed sequence switches the set select on every clock.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
package cs_pkg;
  typedef enum logic {
    FILT_A = 1'b0,
    FILT_B = 1'b1
  } filt_e;

  localparam int unsigned NUM_FILT = 2;
endpackage

// File: rtl/cs_rst_sync.sv
`timescale 1ns/1ps
module cs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/cs_wr_capture.sv
`timescale 1ns/1ps
module cs_wr_capture #(
  parameter int unsigned AW = 9,
  parameter int unsigned CW = 10
) (
  input  logic          wr_strb,
  input  logic          rst_n,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [AW-1:0] hold_addr,
  output logic [CW-1:0] hold_data,
  output logic          hold_tgl
);
  logic tgl_d;

  always_comb tgl_d = ~hold_tgl;

  // strobe domain: one register set per write, toggle marks a new word
  always_ff @(posedge wr_strb or negedge rst_n) begin
    if (!rst_n) begin
      hold_addr <= '0;
      hold_data <= '0;
      hold_tgl  <= 1'b0;
    end else begin
      hold_addr <= wr_addr;
      hold_data <= wr_data;
      hold_tgl  <= tgl_d;
    end
  end
endmodule

// File: rtl/cs_wr_sync.sv
`timescale 1ns/1ps
module cs_wr_sync #(
  parameter int unsigned AW     = 9,
  parameter int unsigned CW     = 10,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned SET_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_tgl,
  input  logic [AW-1:0]     hold_addr,
  input  logic [CW-1:0]     hold_data,
  output logic              cmt_pulse,
  output logic              we_a,
  output logic              we_b,
  output logic [BANK_W-1:0] wr_bank,
  output logic [SET_W-1:0]  wr_set,
  output logic [CW-1:0]     wr_data
);
  import cs_pkg::*;

  localparam int unsigned FILT_BIT = BANK_W;
  localparam int unsigned SET_LSB  = BANK_W + 1;
  localparam int unsigned TAG_BIT  = SET_LSB + SET_W;

  logic [2:0] sync_q;
  logic [2:0] sync_d;
  logic       tag_ok;
  filt_e      filt;

  always_comb sync_d = {sync_q[1:0], hold_tgl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  // one clock wide commit once the toggle has settled in this domain
  assign cmt_pulse = sync_q[1] ^ sync_q[2];

  always_comb begin
    tag_ok  = hold_addr[TAG_BIT];
    filt    = filt_e'(hold_addr[FILT_BIT]);
    wr_bank = hold_addr[BANK_W-1:0];
    wr_set  = hold_addr[SET_LSB +: SET_W];
    wr_data = hold_data;
    we_a    = cmt_pulse && tag_ok && (filt == FILT_A);
    we_b    = cmt_pulse && tag_ok && (filt == FILT_B);
  end

  if (AW != TAG_BIT + 1) begin : g_bad_aw
    initial $error("cs_wr_sync: address width does not match field layout");
  end
endmodule

// File: rtl/cs_bank.sv
`timescale 1ns/1ps
module cs_bank #(
  parameter int unsigned CW    = 10,
  parameter int unsigned NBANK = 4,
  parameter int unsigned NSET  = 32,
  localparam int unsigned BANK_W = $clog2(NBANK),
  localparam int unsigned SET_W  = $clog2(NSET)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [CW-1:0]     wr_data,
  input  logic [SET_W-1:0]  set_sel,
  output logic [NBANK*CW-1:0] coef_q
);
  logic [CW-1:0]       mem [NBANK][NSET];
  logic [NBANK*CW-1:0] coef_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) begin
        for (int s = 0; s < NSET; s++) begin
          mem[b][s] <= '0;
        end
      end
    end else if (we) begin
      mem[wr_bank][wr_set] <= wr_data;
    end
  end

  for (genvar gb = 0; gb < NBANK; gb++) begin : g_lane
    assign coef_d[gb*CW +: CW] = mem[gb][set_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coef_q <= '0;
    else        coef_q <= coef_d;
  end
endmodule

// File: rtl/coef_set_store.sv
`timescale 1ns/1ps
module coef_set_store #(
  parameter int unsigned CW    = 10,
  parameter int unsigned NBANK = 4,
  parameter int unsigned NSET  = 32,
  localparam int unsigned BANK_W = $clog2(NBANK),
  localparam int unsigned SET_W  = $clog2(NSET),
  localparam int unsigned AW     = BANK_W + 1 + SET_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_strb,
  input  logic [AW-1:0]      wr_addr,
  input  logic [CW-1:0]      wr_data,
  input  logic [SET_W-1:0]   set_sel,
  output logic [NBANK*CW-1:0] coef_a,
  output logic [NBANK*CW-1:0] coef_b
);
  import cs_pkg::*;

  logic              rst_n_s;
  logic [AW-1:0]     hold_addr;
  logic [CW-1:0]     hold_data;
  logic              hold_tgl;
  logic              cmt_pulse;
  logic              we_a;
  logic              we_b;
  logic [BANK_W-1:0] wr_bank;
  logic [SET_W-1:0]  wr_set;
  logic [CW-1:0]     cmt_data;
  logic [NUM_FILT-1:0]  we_f;
  logic [NBANK*CW-1:0]  coef_f [NUM_FILT];

  cs_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  cs_wr_capture #(.AW(AW), .CW(CW)) u_cap (
    .wr_strb   (wr_strb),
    .rst_n     (rst_n),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .hold_addr (hold_addr),
    .hold_data (hold_data),
    .hold_tgl  (hold_tgl)
  );

  cs_wr_sync #(.AW(AW), .CW(CW), .BANK_W(BANK_W), .SET_W(SET_W)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .hold_tgl  (hold_tgl),
    .hold_addr (hold_addr),
    .hold_data (hold_data),
    .cmt_pulse (cmt_pulse),
    .we_a      (we_a),
    .we_b      (we_b),
    .wr_bank   (wr_bank),
    .wr_set    (wr_set),
    .wr_data   (cmt_data)
  );

  assign we_f = {we_b, we_a};

  for (genvar gf = 0; gf < NUM_FILT; gf++) begin : g_filt
    cs_bank #(.CW(CW), .NBANK(NBANK), .NSET(NSET)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .we      (we_f[gf]),
      .wr_bank (wr_bank),
      .wr_set  (wr_set),
      .wr_data (cmt_data),
      .set_sel (set_sel),
      .coef_q  (coef_f[gf])
    );
  end

  assign coef_a = coef_f[FILT_A];
  assign coef_b = coef_f[FILT_B];
endmodule

// File: rtl/cs_chk.sv
`timescale 1ns/1ps
module cs_chk #(
  parameter int unsigned AW     = 9,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned SW     = 5,
  parameter int unsigned W      = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmt_pulse,
  input logic          we_a,
  input logic          we_b,
  input logic [AW-1:0] cmt_addr,
  input logic [SW-1:0] set_sel,
  input logic [W-1:0]  coef_a,
  input logic [W-1:0]  coef_b
);
  p_tag_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a || we_b) |-> cmt_addr[AW-1]);

  p_filt_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_b |-> cmt_addr[BANK_W]) and (we_a |-> !cmt_addr[BANK_W]));

  p_write_needs_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a || we_b) |-> cmt_pulse);

  p_single_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_pulse |=> !cmt_pulse);

  p_hold_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cmt_pulse) && $stable(set_sel)) |=> $stable(coef_a));

  p_hold_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cmt_pulse) && $stable(set_sel)) |=> $stable(coef_b));
endmodule

bind coef_set_store cs_chk #(
  .AW(AW), .BANK_W(BANK_W), .SW(SET_W), .W(NBANK*CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .cmt_pulse (cmt_pulse),
  .we_a      (we_a),
  .we_b      (we_b),
  .cmt_addr  (hold_addr),
  .set_sel   (set_sel),
  .coef_a    (coef_a),
  .coef_b    (coef_b)
);

// File: tb/test_coef_set_store.sv
`timescale 1ns/1ps
module test_coef_set_store;
  localparam int CW = 10;
  localparam int NB = 4;
  localparam int NS = 32;

  logic          clk;
  logic          rst_n;
  logic          wr_strb;
  logic [8:0]    wr_addr;
  logic [CW-1:0] wr_data;
  logic [4:0]    set_sel;
  logic [NB*CW-1:0] coef_a;
  logic [NB*CW-1:0] coef_b;

  int nchk;
  int nerr;
  logic [CW-1:0] model [2][NB][NS];

  coef_set_store i_coef_set_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_strb (wr_strb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .set_sel (set_sel),
    .coef_a  (coef_a),
    .coef_b  (coef_b)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [NB*CW-1:0] exp_vec(int f, int s);
    logic [NB*CW-1:0] v;
    for (int k = 0; k < NB; k++) v[k*CW +: CW] = model[f][k][s];
    return v;
  endfunction

  task automatic check_out(int s, string req);
    logic [NB*CW-1:0] ea;
    logic [NB*CW-1:0] eb;
    ea = exp_vec(0, s);
    eb = exp_vec(1, s);
    nchk += 2;
    if (coef_a !== ea) begin
      nerr++;
      $display("FAIL %s coef_a set %0d: got %h expected %h", req, s, coef_a, ea);
    end
    if (coef_b !== eb) begin
      nerr++;
      $display("FAIL %s coef_b set %0d: got %h expected %h", req, s, coef_b, eb);
    end
  endtask

  // select a set at a falling edge, sample after the next rising edge
  task automatic read_set(int s, string req);
    @(negedge clk);
    set_sel = 5'(s);
    @(negedge clk);
    check_out(s, req);
  endtask

  // strobe edge at a random point in the clock period; optional scramble after it
  task automatic do_write(logic [8:0] a, logic [CW-1:0] d, bit scramble);
    @(negedge clk);
    #($urandom_range(0, 4));
    wr_addr = a;
    wr_data = d;
    #0.5 wr_strb = 1'b1;
    #1;
    if (scramble) begin
      wr_addr = 9'($urandom);
      wr_data = 10'($urandom);
    end
    #1 wr_strb = 1'b0;
    if (a[8]) model[a[2]][a[1:0]][a[7:3]] = d;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(150000 * 5);
    nerr++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    nchk = 0;
    nerr = 0;
    for (int f = 0; f < 2; f++)
      for (int b = 0; b < NB; b++)
        for (int s = 0; s < NS; s++) model[f][b][s] = '0;
    rst_n   = 1'b0;
    wr_strb = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    set_sel = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset contents are zero
    read_set(0, "R1");
    read_set(31, "R1");
    read_set(13, "R1");

    // R2: tagged example address, set 7 bank 3 of the A filter
    do_write(9'b1_00111_0_11, 10'h2C5, 1'b0);
    read_set(7, "R2");
    do_write(9'b1_00111_1_01, 10'h13A, 1'b0);
    read_set(7, "R2");

    // R3: tag clear leaves storage unchanged
    do_write(9'b1_00101_0_10, 10'h155, 1'b0);
    do_write(9'b0_00101_0_10, 10'h2AA, 1'b0);
    read_set(5, "R3");
    do_write(9'b0_00111_0_11, 10'h3FF, 1'b0);
    read_set(7, "R3");

    // R4: scrambled address and data after the strobe edge
    do_write(9'b1_11110_1_00, 10'h0F1, 1'b1);
    read_set(30, "R4");

    // R5: latency bound, set already selected before the strobe
    @(negedge clk);
    set_sel = 5'd19;
    @(negedge clk);
    wr_addr = 9'b1_10011_0_01;
    wr_data = 10'h377;
    #1 wr_strb = 1'b1;
    #1 wr_strb = 1'b0;
    model[0][1][19] = 10'h377;
    repeat (5) @(posedge clk);
    #1 check_out(19, "R5");
    repeat (2) @(negedge clk);

    // R6: selection switched on every clock
    @(negedge clk);
    set_sel = 5'd7;
    for (int i = 0; i < 12; i++) begin
      int nxt;
      int cur;
      cur = set_sel;
      nxt = (i % 3 == 0) ? 5 : ((i % 3 == 1) ? 30 : 7);
      @(negedge clk);
      check_out(cur, "R6");
      set_sel = 5'(nxt);
    end

    // R7: outputs hold with a steady select and no write
    read_set(30, "R7");
    repeat (5) begin
      @(negedge clk);
      check_out(30, "R7");
    end

    // random writes (some tag clear, some scrambled) with spot reads
    for (int i = 0; i < 160; i++) begin
      logic [8:0] a;
      a = 9'($urandom);
      a[8] = ($urandom_range(0, 3) != 0);
      do_write(a, 10'($urandom), bit'($urandom_range(0, 1)));
      if (i % 4 == 0) read_set(int'(a[7:3]), "R5");
      if (i % 9 == 0) read_set($urandom_range(0, NS - 1), "R3");
    end

    // full sweep of every set
    for (int s = 0; s < NS; s++) read_set(s, "R2");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule